// File: doc/BRIEF.md
# Registered Wired-OR Bus Transceiver Controller

This block holds the digital datapath and direction control of a 10-bit half-duplex transceiver. It sits between a logic-side port (the A side) and an open-collector backplane port (the B side). The block carries eight data bits in two 4-bit groups and two clock/data lanes. It also provides an auxiliary input that can be steered onto the second bus lane and an auxiliary output that returns the value received on that lane. Each logic-side line is modelled as a value plus a drive enable. Each backplane line is modelled as a pull-down request: a logic high is a released line, and the external pull-up sets its level.

A direction pair selects transmit, receive or standby. In transmit, a mode input chooses one of two paths toward the bus. The transparent path passes the logic-side data straight through. The registered path forwards data captured on the rising edge of the logic-side bus clock pin. A master/slave input gates the lane-1 clock transmitter. A power-ready input holds every backplane driver off while supplies settle. The bus clock pin can be turned around so that it outputs the received lane-1 value.

Top module: `wox_xcvr`

## Requirements
- R1: After reset the capture register holds all ones. Selecting the registered transmit path before any clock-pin edge therefore pulls no data line and, with `xmit_en_n`=0, does not pull lane 2.
- R2: With `reg_mode`=0 and the data transmit path enabled, `b_data_pd` equals the bitwise inverse of `a_data_i` in the same cycle.
- R3: With `reg_mode`=1, `{alt_in_i, a_data_i}` is captured at the first system clock edge that samples `a_bclk_i` high after it was sampled low. The B side then reflects the captured value, and later changes of `a_data_i` have no effect until the next such edge.
- R4: Data lines are pulled only when all of these hold: `tx_mode`=1, `rx_mode`=0, `pwr_ready`=1, `xmit_en_n`=0 and `grp_rx_en_n`=2'b11. Otherwise `b_data_pd` is zero.
- R5: When receiving (`rx_mode`=1, `tx_mode`=0), group g (bits 4g+3..4g) and lane g drive the A side from the B side only when `grp_rx_en_n[g]`=0. The groups act independently, and an undriven output reads zero.
- R6: Lane 1 transmits `a_lane_i[0]` onto `b_lane_pd[0]` only in powered transmit with `slave_sel`=0 and `grp_rx_en_n[0]`=1.
- R7: While `pwr_ready`=0, no backplane line (data or lane) is pulled.
- R8: The bus clock pin drives `a_bclk_o`=`b_lane_i[0]` only when `clk_pin_in_n`=0 and the block is in transmit or receive. Otherwise it is an input (`a_bclk_oe`=0).
- R9: Lane 2 transmits in powered transmit when `grp_rx_en_n[1]`=1. Its source is `alt_in_i` when `xmit_en_n`=0 (the captured copy when `reg_mode`=1) and `a_lane_i[1]` when `xmit_en_n`=1.
- R10: In receive, `alt_out_oe`=1 and `alt_out_o`=`b_lane_i[1]`. Otherwise both are zero.
- R11: A backplane line is pulled only for a logic low source bit. A high source bit leaves it released.
- R12: When `tx_mode` equals `rx_mode` (standby), every drive enable and every pull-down is off.
- R13: No data bit or lane is driven by the block on its A side and pulled on its B side in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xmit_en_n | input | 1 | Data transmit enable, active low |
| grp_rx_en_n | input | 2 | Per-group receive enables, active low |
| clk_pin_in_n | input | 1 | Bus clock pin direction: 1 input, 0 output |
| slave_sel | input | 1 | 0 master (lane-1 transmitter on), 1 slave |
| reg_mode | input | 1 | 0 transparent path, 1 registered path |
| rx_mode | input | 1 | Receive direction select |
| tx_mode | input | 1 | Transmit direction select |
| pwr_ready | input | 1 | Low holds all backplane drivers off |
| a_data_i | input | 8 | Logic-side data in |
| a_data_o | output | 8 | Logic-side data out |
| a_grp_oe | output | 2 | Logic-side drive enable per data group |
| a_lane_i | input | 2 | Logic-side lane values in |
| a_lane_o | output | 2 | Logic-side lane values out |
| a_lane_oe | output | 2 | Logic-side lane drive enables |
| a_bclk_i | input | 1 | Bus clock pin input value |
| a_bclk_o | output | 1 | Bus clock pin output value |
| a_bclk_oe | output | 1 | Bus clock pin drive enable |
| alt_in_i | input | 1 | Auxiliary input toward lane 2 |
| alt_out_o | output | 1 | Auxiliary output from lane 2 |
| alt_out_oe | output | 1 | Auxiliary output enable |
| b_data_i | input | 8 | Backplane data levels |
| b_data_pd | output | 8 | Backplane data pull-down requests |
| b_lane_i | input | 2 | Backplane lane levels |
| b_lane_pd | output | 2 | Backplane lane pull-down requests |

## Verification
The embedded properties watch several relations on every cycle: standby silence, the power inhibit, the slave gating of lane 1, the direction of the clock pin and the auxiliary output value. They also check that no line is driven from both sides, that a high source bit never becomes a pull, and that the capture register is updated only on a sampled rising edge of the clock pin and is stable otherwise. The bench sweeps every combination of the nine control inputs under several data and bus patterns. This sweep is the only way to show that the full enable equations, the lane-2 source selection and the per-group receive split match the mode table. The bench also shows that data changed after a capture stays invisible on the registered path and that the reset value releases the bus.

// File: rtl/wox_pkg.sv
package wox_pkg;

    // Number of data groups; each group is paired with one lane.
    localparam int N_GRP = 2;

    // Decoded drive permissions for one cycle.
    typedef struct packed {
        logic             data_tx;   // pull B data lines from the selected source
        logic [N_GRP-1:0] lane_tx;   // pull B lanes
        logic             lane2_alt; // lane 2 source is the auxiliary input
        logic [N_GRP-1:0] grp_rx;    // drive A data group and lane from B
        logic             bclk_out;  // bus clock pin turned to output
        logic             alt_out;   // auxiliary output driven
    } drive_en_t;

endpackage

// File: rtl/wox_mode_dec.sv
module wox_mode_dec
    import wox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xmit_en_n,
    input  logic [N_GRP-1:0] grp_rx_en_n,
    input  logic             clk_pin_in_n,
    input  logic             slave_sel,
    input  logic             rx_mode,
    input  logic             tx_mode,
    input  logic             pwr_ready,
    output drive_en_t        en_o
);

    logic tx_on;
    logic rx_on;
    logic drive_ok;

    always_comb begin
        tx_on    = tx_mode & ~rx_mode;
        rx_on    = rx_mode & ~tx_mode;
        drive_ok = tx_on & pwr_ready;

        en_o           = '0;
        en_o.data_tx   = drive_ok & ~xmit_en_n & (&grp_rx_en_n);
        en_o.lane_tx[0] = drive_ok & ~slave_sel & grp_rx_en_n[0];
        en_o.lane_tx[1] = drive_ok & grp_rx_en_n[1];
        en_o.lane2_alt = ~xmit_en_n;
        en_o.grp_rx    = {N_GRP{rx_on}} & ~grp_rx_en_n;
        en_o.bclk_out  = ~clk_pin_in_n & (tx_on | rx_on);
        en_o.alt_out   = rx_on;
    end

    // R12
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == rx_mode) |-> (!en_o.data_tx && en_o.lane_tx == '0 &&
                                  en_o.grp_rx == '0 && !en_o.bclk_out && !en_o.alt_out));

    // R7
    power_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ready |-> (!en_o.data_tx && en_o.lane_tx == '0));

    // R6
    slave_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_sel |-> !en_o.lane_tx[0]);

endmodule

// File: rtl/wox_cap_reg.sv
module wox_cap_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] cap;
        logic         prev;
    } cap_state_t;

    cap_state_t st_d;
    cap_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe_i;
        if (strobe_i && !st_q.prev) begin
            st_d.cap = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cap  <= '1;
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.cap;

    // R3
    capture_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(strobe_i)) |=> (dout == $past(din)));

    // R3
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$rose(strobe_i)) |=> $stable(dout));

endmodule

// File: rtl/wox_oc_drv.sv
module wox_oc_drv #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] pd_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pd_o[i] = en_i[i] & ~val_i[i];
    end

endmodule

// File: rtl/wox_xcvr.sv
module wox_xcvr
    import wox_pkg::*;
#(
    parameter  int GRP_W = 4,
    localparam int DW    = GRP_W * N_GRP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xmit_en_n,
    input  logic [N_GRP-1:0] grp_rx_en_n,
    input  logic             clk_pin_in_n,
    input  logic             slave_sel,
    input  logic             reg_mode,
    input  logic             rx_mode,
    input  logic             tx_mode,
    input  logic             pwr_ready,
    input  logic [DW-1:0]    a_data_i,
    output logic [DW-1:0]    a_data_o,
    output logic [N_GRP-1:0] a_grp_oe,
    input  logic [N_GRP-1:0] a_lane_i,
    output logic [N_GRP-1:0] a_lane_o,
    output logic [N_GRP-1:0] a_lane_oe,
    input  logic             a_bclk_i,
    output logic             a_bclk_o,
    output logic             a_bclk_oe,
    input  logic             alt_in_i,
    output logic             alt_out_o,
    output logic             alt_out_oe,
    input  logic [DW-1:0]    b_data_i,
    output logic [DW-1:0]    b_data_pd,
    input  logic [N_GRP-1:0] b_lane_i,
    output logic [N_GRP-1:0] b_lane_pd
);

    drive_en_t        en;
    logic [DW:0]      cap;
    logic [DW-1:0]    data_src;
    logic             lane2_src;
    logic [N_GRP-1:0] lane_src;
    logic [DW-1:0]    grp_oe_bits;

    wox_mode_dec u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .xmit_en_n    (xmit_en_n),
        .grp_rx_en_n  (grp_rx_en_n),
        .clk_pin_in_n (clk_pin_in_n),
        .slave_sel    (slave_sel),
        .rx_mode      (rx_mode),
        .tx_mode      (tx_mode),
        .pwr_ready    (pwr_ready),
        .en_o         (en)
    );

    wox_cap_reg #(.W(DW + 1)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (a_bclk_i),
        .din      ({alt_in_i, a_data_i}),
        .dout     (cap)
    );

    always_comb begin
        data_src  = reg_mode ? cap[DW-1:0] : a_data_i;
        if (en.lane2_alt) begin
            lane2_src = reg_mode ? cap[DW] : alt_in_i;
        end else begin
            lane2_src = a_lane_i[1];
        end
        lane_src = {lane2_src, a_lane_i[0]};
    end

    wox_oc_drv #(.W(DW)) u_data_drv (
        .val_i (data_src),
        .en_i  ({DW{en.data_tx}}),
        .pd_o  (b_data_pd)
    );

    wox_oc_drv #(.W(N_GRP)) u_lane_drv (
        .val_i (lane_src),
        .en_i  (en.lane_tx),
        .pd_o  (b_lane_pd)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_rx
        assign a_data_o[g*GRP_W +: GRP_W] = en.grp_rx[g] ? b_data_i[g*GRP_W +: GRP_W] : '0;
        assign grp_oe_bits[g*GRP_W +: GRP_W] = {GRP_W{en.grp_rx[g]}};
        assign a_lane_o[g] = en.grp_rx[g] & b_lane_i[g];
    end

    assign a_grp_oe   = en.grp_rx;
    assign a_lane_oe  = en.grp_rx;
    assign a_bclk_oe  = en.bclk_out;
    assign a_bclk_o   = en.bclk_out & b_lane_i[0];
    assign alt_out_oe = en.alt_out;
    assign alt_out_o  = en.alt_out & b_lane_i[1];

    // R13
    no_fight_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_oe_bits & b_data_pd) == '0);

    // R13
    no_fight_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_lane_oe & b_lane_pd) == '0);

    // R11
    released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_mode |-> ((b_data_pd & a_data_i) == '0));

    // R7
    bus_quiet_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ready |-> (b_data_pd == '0 && b_lane_pd == '0));

    // R8
    clk_pin_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pin_in_n |-> !a_bclk_oe);

    // R10
    alt_out_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_out_oe |-> (alt_out_o == b_lane_i[1]));

endmodule

// File: tb/test_wox_xcvr.sv
module test_wox_xcvr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xmit_en_n, clk_pin_in_n, slave_sel, reg_mode, rx_mode, tx_mode, pwr_ready;
    logic [1:0] grp_rx_en_n, a_lane_i, b_lane_i;
    logic [7:0] a_data_i, b_data_i;
    logic       a_bclk_i, alt_in_i;
    logic [7:0] a_data_o, b_data_pd;
    logic [1:0] a_grp_oe, a_lane_o, a_lane_oe, b_lane_pd;
    logic       a_bclk_o, a_bclk_oe, alt_out_o, alt_out_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [8:0] exp_cap;

    always #5 clk = ~clk;

    wox_xcvr i_wox_xcvr (
        .clk(clk), .rst_n(rst_n), .xmit_en_n(xmit_en_n), .grp_rx_en_n(grp_rx_en_n),
        .clk_pin_in_n(clk_pin_in_n), .slave_sel(slave_sel), .reg_mode(reg_mode),
        .rx_mode(rx_mode), .tx_mode(tx_mode), .pwr_ready(pwr_ready),
        .a_data_i(a_data_i), .a_data_o(a_data_o), .a_grp_oe(a_grp_oe),
        .a_lane_i(a_lane_i), .a_lane_o(a_lane_o), .a_lane_oe(a_lane_oe),
        .a_bclk_i(a_bclk_i), .a_bclk_o(a_bclk_o), .a_bclk_oe(a_bclk_oe),
        .alt_in_i(alt_in_i), .alt_out_o(alt_out_o), .alt_out_oe(alt_out_oe),
        .b_data_i(b_data_i), .b_data_pd(b_data_pd), .b_lane_i(b_lane_i), .b_lane_pd(b_lane_pd)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic set_ctrl(input logic [8:0] c);
        xmit_en_n    = c[0];
        grp_rx_en_n  = c[2:1];
        clk_pin_in_n = c[3];
        slave_sel    = c[4];
        reg_mode     = c[5];
        rx_mode      = c[6];
        tx_mode      = c[7];
        pwr_ready    = c[8];
    endtask

    // Expected outputs derived from the requirement list.
    task automatic check_all();
        logic tx, rx, txp, d_en, l1_en, l2_en, l2_src;
        logic [7:0] src, e_pd, e_ado;
        logic [1:0] e_grp, e_lpd, e_lo;
        string dtag;
        tx    = tx_mode & ~rx_mode;
        rx    = rx_mode & ~tx_mode;
        txp   = tx & pwr_ready;
        d_en  = txp & ~xmit_en_n & grp_rx_en_n[0] & grp_rx_en_n[1];
        src   = reg_mode ? exp_cap[7:0] : a_data_i;
        e_pd  = d_en ? ~src : 8'h00;
        l1_en = txp & ~slave_sel & grp_rx_en_n[0];
        l2_en = txp & grp_rx_en_n[1];
        l2_src = ~xmit_en_n ? (reg_mode ? exp_cap[8] : alt_in_i) : a_lane_i[1];
        e_lpd = {l2_en & ~l2_src, l1_en & ~a_lane_i[0]};
        e_grp = {rx & ~grp_rx_en_n[1], rx & ~grp_rx_en_n[0]};
        e_ado = {(e_grp[1] ? b_data_i[7:4] : 4'h0), (e_grp[0] ? b_data_i[3:0] : 4'h0)};
        e_lo  = e_grp & b_lane_i;

        if (tx_mode == rx_mode)         dtag = "R12";
        else if (tx && !pwr_ready)      dtag = "R7";
        else if (!d_en)                 dtag = "R4";
        else if (reg_mode)              dtag = "R3";
        else                            dtag = "R2";

        chk(dtag, b_data_pd, e_pd);
        chk("R6 lane1", b_lane_pd[0], e_lpd[0]);
        chk("R9 lane2", b_lane_pd[1], e_lpd[1]);
        chk("R5 data", {a_grp_oe, a_data_o}, {e_grp, e_ado});
        chk("R5 lane", {a_lane_oe, a_lane_o}, {e_grp, e_lo});
        chk("R8", {a_bclk_oe, a_bclk_o},
            {~clk_pin_in_n & (tx | rx), ~clk_pin_in_n & (tx | rx) & b_lane_i[0]});
        chk("R10", {alt_out_oe, alt_out_o}, {rx, rx & b_lane_i[1]});
        chk("R13", {({{4{a_grp_oe[1]}}, {4{a_grp_oe[0]}}} & b_data_pd), (a_lane_oe & b_lane_pd)}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        set_ctrl(9'h000);
        a_data_i = 8'h00; b_data_i = 8'h00; a_lane_i = 2'b00; b_lane_i = 2'b00;
        a_bclk_i = 1'b0; alt_in_i = 1'b0;
        exp_cap = 9'h1FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value releases bus on the registered path.
        @(negedge clk);
        set_ctrl({1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0});
        a_data_i = 8'h00; alt_in_i = 1'b0;
        #2;
        chk("R1 data", b_data_pd, 8'h00);
        chk("R1 lane2", b_lane_pd[1], 1'b0);

        // R11: all-high source in transparent path leaves every line released.
        @(negedge clk);
        reg_mode = 1'b0; a_data_i = 8'hFF;
        #2;
        chk("R11", b_data_pd, 8'h00);
        a_data_i = 8'h5A;
        #1;
        chk("R11 mixed", b_data_pd, 8'hA5);

        for (int v = 0; v < 512; v++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] pat;
                pat = 8'((v * 37 + p * 91 + 13) & 8'hFF);
                @(negedge clk);
                set_ctrl(9'(v));
                a_data_i = pat;
                alt_in_i = p[0];
                a_bclk_i = 1'b0;
                a_lane_i = 2'(p) ^ 2'(v);
                b_lane_i = 2'(p >> 1) ^ 2'(v >> 3);
                b_data_i = ~pat ^ 8'(v);
                @(negedge clk);
                a_bclk_i = 1'b1;
                @(negedge clk);
                exp_cap  = {alt_in_i, a_data_i};
                a_data_i = ~pat;      // R3: must not reach the registered path
                alt_in_i = ~p[0];
                #2;
                check_all();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule